// File: doc/BRIEF.md
# Serial Disk Word Deserializer with Self-Aligning Sync

This block turns the free-running serial bit stream read back from a disk head into parallel words. Each bit arrives with a one-cycle enable in the system clock domain. The bit is shifted left into a word-wide input register, and the newest bit enters at the least significant end. The block has no pattern comparator. Word alignment comes from the stream itself: gaps between fields are filled with marker words. Each marker word is a single 1 as its first serial bit, followed by zeros. Once the 1 has been shifted all the way up to the most significant bit, the marker word sits complete in the register.

After reset, and whenever the controlling task re-arms it, the block is in hunting mode. The first accepted bit that puts a 1 into the register's top bit is a sync event. The block sets its lock flag and sends a one-cycle wake request to the controlling task. It then throws away the marker word that caused the sync. From that point it delivers one word, with a one-cycle valid strobe, for every 16 further bits. Before a field starts, the controlling task clears the lock flag about one word early. The next marker word then realigns the stream, so the first word delivered is the first field word. A sticky flag reports any word that was overwritten before it was acknowledged.

Top module: `disk_word_deser`

## Requirements
- R1: While rst_n is low, and for the cycles in which the internal reset is still being released, sync_flag, wake, word_vld and overrun are 0 and word_o is 0.
- R2: Each clock edge with bit_en high shifts the input register left by one and puts bit_in at bit 0. A delivered word therefore has the first of its 16 serial bits at bit 15.
- R3: While hunting, an accepted bit that makes bit 15 of the input register equal to 1 is a sync event. It sets sync_flag, and wake is high for exactly the one cycle after that bit's edge.
- R4: The marker word that completes a sync is never delivered. The first word_vld pulse comes one cycle after the 16th accepted bit following the sync bit, and word_o then holds those 16 bits.
- R5: While locked, word_vld pulses for one cycle after every 16th accepted bit. A 1 reaching bit 15 in this mode raises no wake and does not realign the stream.
- R6: A cycle with hunt_clr high leaves sync_flag at 0 afterwards. No word is delivered while hunting. A bit accepted in the same cycle as hunt_clr is shifted in, but it neither completes a word nor triggers a sync.
- R7: word_o keeps the last delivered word until the next word_vld pulse.
- R8: overrun becomes 1 when a word is delivered while the previous word is still unacknowledged, and it stays 1 until reset. A word_ack pulse acknowledges the pending word, and an acknowledgement in the same cycle as a new delivery counts for the older word.
- R9: Cycles with bit_en low change neither the bit position nor the lock state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_en | input | 1 | One-cycle qualifier: bit_in is accepted at this edge |
| bit_in | input | 1 | Serial read data bit |
| hunt_clr | input | 1 | Clears the lock flag and re-enters hunting mode |
| word_ack | input | 1 | Acknowledges the word currently on word_o |
| word_o | output | 16 | Last delivered word, first serial bit at the MSB |
| word_vld | output | 1 | One-cycle strobe: a new word is on word_o |
| wake | output | 1 | One-cycle wake request raised on a sync event |
| sync_flag | output | 1 | Lock flag: 1 once synced, 0 while hunting |
| overrun | output | 1 | Sticky flag: a word was overwritten before acknowledgement |

## Verification
The bound checker watches several properties on every cycle. It checks that wake is a single-cycle pulse, that it only comes from an accepted bit while hunting, and that it never coincides with a word strobe. It checks that words appear only after an accepted bit and only while locked, that hunt_clr always drops the lock, that the lock holds on its own, and that overrun never clears. Some behaviour only the bench's scenarios can show. These are the exact bit that triggers the sync at each of the 16 phase offsets, and the discarding of the marker word. They also include the 16-bit spacing and content of delivered words, the abort of a word when hunt_clr coincides with its last bit, and the point at which an unacknowledged word turns into an overrun.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_e;
endpackage

// File: rtl/deser_rst_sync.sv
module deser_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/deser_shift.sv
module deser_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] shift_nxt
);
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_n;

  always_comb begin
    shift_n = shift_q;
    if (bit_en) shift_n = {shift_q[WORD_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_n;
  end

  assign shift_nxt = shift_n;
endmodule

// File: rtl/deser_align.sv
module deser_align
  import deser_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic hunt_clr,
  input  logic msb_nxt,
  output logic sync_flag,
  output logic wake,
  output logic word_stb
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  lock_e            state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             wake_q, wake_n;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    wake_n   = 1'b0;
    word_stb = 1'b0;
    if (hunt_clr) begin
      state_n = ST_HUNT;
      cnt_n   = '0;
    end else if (bit_en) begin
      unique case (state_q)
        ST_HUNT: begin
          if (msb_nxt) begin
            state_n = ST_LOCK;
            cnt_n   = '0;
            wake_n  = 1'b1;
          end
        end
        ST_LOCK: begin
          if (cnt_q == LAST) begin
            cnt_n    = '0;
            word_stb = 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: state_n = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      wake_q  <= wake_n;
    end
  end

  assign sync_flag = (state_q == ST_LOCK);
  assign wake      = wake_q;
endmodule

// File: rtl/deser_outreg.sv
module deser_outreg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic              word_ack,
  input  logic [WORD_W-1:0] shift_nxt,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld,
  output logic              overrun
);
  logic [WORD_W-1:0] word_q, word_n;
  logic              vld_q, vld_n;
  logic              pend_q, pend_n;
  logic              ovr_q, ovr_n;

  always_comb begin
    word_n = word_q;
    vld_n  = word_stb;
    pend_n = pend_q;
    ovr_n  = ovr_q;
    if (word_stb) begin
      word_n = shift_nxt;
      pend_n = 1'b1;
      if (pend_q && !word_ack) ovr_n = 1'b1;
    end else if (word_ack) begin
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      word_q <= word_n;
      vld_q  <= vld_n;
      pend_q <= pend_n;
      ovr_q  <= ovr_n;
    end
  end

  assign word_o   = word_q;
  assign word_vld = vld_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/disk_word_deser.sv
module disk_word_deser #(
  parameter int WORD_W    = 16,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              hunt_clr,
  input  logic              word_ack,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld,
  output logic              wake,
  output logic              sync_flag,
  output logic              overrun
);
  logic              rst_sync_n;
  logic [WORD_W-1:0] shift_nxt;
  logic              word_stb;

  deser_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  deser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .shift_nxt (shift_nxt)
  );

  deser_align #(.WORD_W(WORD_W)) u_align (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_en    (bit_en),
    .hunt_clr  (hunt_clr),
    .msb_nxt   (shift_nxt[WORD_W-1]),
    .sync_flag (sync_flag),
    .wake      (wake),
    .word_stb  (word_stb)
  );

  deser_outreg #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .word_stb  (word_stb),
    .word_ack  (word_ack),
    .shift_nxt (shift_nxt),
    .word_o    (word_o),
    .word_vld  (word_vld),
    .overrun   (overrun)
  );
endmodule

// File: rtl/deser_chk.sv
module deser_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic hunt_clr,
  input logic word_vld,
  input logic wake,
  input logic sync_flag,
  input logic overrun
);
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake); // R3
  AST_WAKE_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($past(bit_en) && !$past(sync_flag) && !$past(hunt_clr) && sync_flag)); // R3
  AST_NO_MARKER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !word_vld); // R4
  AST_WORD_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> ($past(bit_en) && $past(sync_flag) && !$past(hunt_clr))); // R5
  AST_CLR_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_clr |=> !sync_flag); // R6
  AST_NO_WORD_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> sync_flag); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_flag && !hunt_clr) |=> sync_flag); // R9
  AST_IDLE_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_flag && !bit_en) |=> !sync_flag); // R9
endmodule

bind disk_word_deser deser_chk i_deser_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .hunt_clr  (hunt_clr),
  .word_vld  (word_vld),
  .wake      (wake),
  .sync_flag (sync_flag),
  .overrun   (overrun)
);

// File: tb/test_disk_word_deser.sv
module test_disk_word_deser;
  localparam int W = 16;

  logic         clk;
  logic         rst_n;
  logic         bit_en;
  logic         bit_in;
  logic         hunt_clr;
  logic         word_ack;
  logic [W-1:0] word_o;
  logic         word_vld;
  logic         wake;
  logic         sync_flag;
  logic         overrun;

  int  n_chk;
  int  n_err;
  bit  done;

  disk_word_deser i_disk_word_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .hunt_clr  (hunt_clr),
    .word_ack  (word_ack),
    .word_o    (word_o),
    .word_vld  (word_vld),
    .wake      (wake),
    .sync_flag (sync_flag),
    .overrun   (overrun)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic pulse_clr();
    hunt_clr = 1'b1;
    @(negedge clk);
    hunt_clr = 1'b0;
  endtask

  task automatic pulse_ack();
    word_ack = 1'b1;
    @(negedge clk);
    word_ack = 1'b0;
  endtask

  // marker word: a leading 1 then 15 zeros; sync expected on its last bit
  task automatic send_marker(input string tag);
    for (int i = 0; i < W; i++) begin
      send_bit(i == 0);
      if (i < W - 1) chk({tag, " R3 no early wake"}, wake, 0);
    end
    chk({tag, " R3 wake on sync bit"}, wake, 1);
    chk({tag, " R3 lock set"}, sync_flag, 1);
    chk({tag, " R4 marker not delivered"}, word_vld, 0);
    @(negedge clk);
    chk({tag, " R3 wake single cycle"}, wake, 0);
  endtask

  // send a word MSB-first while locked, check strobe timing and content
  task automatic send_word(input string tag, input logic [W-1:0] d);
    for (int i = W - 1; i >= 0; i--) begin
      send_bit(d[i]);
      chk({tag, " R5 no wake while locked"}, wake, 0);
      if (i > 0) chk({tag, " R5 no strobe mid-word"}, word_vld, 0);
    end
    chk({tag, " R4 strobe after 16th bit"}, word_vld, 1);
    chk({tag, " R2 word content"}, word_o, d);
  endtask

  initial begin
    logic [W-1:0] d;
    n_chk    = 0;
    n_err    = 0;
    done     = 0;
    rst_n    = 1'b0;
    bit_en   = 1'b0;
    bit_in   = 1'b0;
    hunt_clr = 1'b0;
    word_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset sync_flag", sync_flag, 0);
    chk("R1 reset wake", wake, 0);
    chk("R1 reset word_vld", word_vld, 0);
    chk("R1 reset overrun", overrun, 0);
    chk("R1 reset word_o", word_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {sync_flag, wake, word_vld, overrun}, 0);

    // sweep every phase offset of the marker relative to clear
    for (int p = 0; p < W; p++) begin
      pulse_clr();
      chk("R6 clear unlocks", sync_flag, 0);
      for (int z = 0; z < p; z++) begin
        send_bit(1'b0);
        chk("R6 no word while hunting", word_vld, 0);
        chk("R3 zeros give no wake", wake, 0);
      end
      send_marker("sweep");
      for (int w = 0; w < 3; w++) begin
        d = (w == 2) ? '0 : (W'(16'hB00F) ^ W'(p * 16'h0931) ^ W'(w * 16'h5A5A));
        send_word("sweep", d);
        pulse_ack();
        chk("R8 acked words no overrun", overrun, 0);
        if (p == 0 && w == 0) begin
          repeat (5) begin
            @(negedge clk);
            chk("R9 idle no strobe", word_vld, 0);
            chk("R7 word held", word_o, d);
            chk("R9 lock held while idle", sync_flag, 1);
          end
        end
      end
    end

    // hunt_clr coinciding with the 16th bit aborts the word
    for (int i = 0; i < W - 1; i++) send_bit(1'b0);
    @(negedge clk);
    bit_en   = 1'b1;
    bit_in   = 1'b0;
    hunt_clr = 1'b1;
    @(negedge clk);
    bit_en   = 1'b0;
    hunt_clr = 1'b0;
    chk("R6 clear with last bit no strobe", word_vld, 0);
    chk("R6 clear with last bit unlocks", sync_flag, 0);
    chk("R7 word_o unchanged", word_o, 0);

    // a 1 reaching the top bit while locked must not resync
    send_marker("relock");
    send_word("R5 ones while locked", 16'h7FFF);
    pulse_ack();
    send_word("R5 spacing kept", 16'hC3A5);
    pulse_ack();

    // overrun: two words without acknowledgement
    send_word("ovr first", 16'h1234);
    chk("R8 one pending no overrun", overrun, 0);
    send_word("ovr second", 16'hFEDC);
    @(negedge clk);
    chk("R8 overrun set", overrun, 1);
    pulse_ack();
    repeat (3) @(negedge clk);
    chk("R8 overrun sticky", overrun, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R1-to-end: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule